// File: doc/BRIEF.md
# Dead-Time Insertion Unit

This block sits between a three-phase PWM source and the gate drivers of a half-bridge inverter. Each phase has an upper and a lower switch, which gives six turn-on request lines. Every request line has its own gate output. When a request turns on, the matching gate output waits for a programmable dead time before it turns on. When a request turns off, the gate turns off at the next clock. The delay gives the opposite switch of the same leg time to stop conducting before this one starts.

The dead time is a count of periods of a count clock. The count clock is either the system clock or a free-running half-rate enable derived from it. A single control input bypasses the delay so that each gate follows its request. Each of the six channels has its own counter, so the channels are timed independently of one another.

Top module: `dti_top`

## Requirements
- R1: While `rst` is high and on the first clock after it, every bit of `gate` is 0 and every channel counter is cleared.
- R2: When `req[i]` is sampled low at a rising clock edge, `gate[i]` is 0 after that same edge, whatever the counter state.
- R3: With `dt_disable`=0, `half_rate`=0 and `dt_count`=n≥1, `gate[i]` goes to 1 after the (n+1)-th rising edge, counting the first edge at which `req[i]` is sampled high. It stays 0 before that edge.
- R4: With `half_rate`=1, the count advances only on every second clock edge, driven by a free-running toggle. `gate[i]` then goes to 1 after the (2n+1)-th or the (2n+2)-th edge of the request, depending on the toggle phase.
- R5: With `dt_disable`=1, `gate[i]` equals the value `req[i]` had at the previous rising edge.
- R6: With `dt_count`=0, `gate[i]` equals the value `req[i]` had at the previous rising edge, just as in bypass.
- R7: If `req[i]` drops before its count expires, `gate[i]` never goes high during that request. The next request then waits the full dead time again from zero.
- R8: Each channel counts on its own. Requests on different channels at different times produce rises that are each timed from their own request.
- R9: If `req[i]` is sampled low at the same edge at which its count would expire, the turn-off wins and `gate[i]` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dt_disable | input | 1 | 1 bypasses dead time, 0 inserts it |
| half_rate | input | 1 | 0 counts every clock, 1 counts every second clock |
| dt_count | input | CNT_W | Dead time in count-clock periods |
| req | input | 2*PHASES | Raw turn-on requests, bit 2p upper and bit 2p+1 lower of phase p |
| gate | output | 2*PHASES | Registered gate outputs with turn-on delay |

## Verification
The turn-off path and the expiry of the count can meet in the same cycle. This happens when a request is withdrawn at exactly the edge at which its counter would have released the gate. The bench provokes this by raising a request and dropping it so that the low level is sampled at the (n+1)-th edge. Before that edge it checks that the gate is still low, and afterwards that it stays low for many cycles. A second full request on the same channel must then show the complete dead time again. This shows that the counter was cleared and not left at its terminal value.

// File: rtl/dti_pkg.sv
package dti_pkg;
  // Number of inverter legs; each leg has an upper and a lower switch.
  parameter int unsigned DEF_PHASES = 3;
  parameter int unsigned DEF_CNT_W  = 8;

  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;

  function automatic int unsigned chan_count(input int unsigned phases);
    return 2 * phases;
  endfunction
endpackage

// File: rtl/dti_tick_gen.sv
module dti_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic half_rate,
  output logic tick
);
  import dti_pkg::*;

  logic phase_q;

  // Free-running toggle, never restarted by the channels.
  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ~phase_q;
  end

  always_comb begin
    unique case (rate_e'(half_rate))
      RATE_HALF: tick = phase_q;
      default:   tick = 1'b1;
    endcase
  end
endmodule

// File: rtl/dti_channel.sv
module dti_channel #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             dt_disable,
  input  logic [CNT_W-1:0] dt_count,
  input  logic             req,
  output logic             gate
);
  logic [CNT_W-1:0] cnt_q;
  logic             gate_q;
  logic             no_delay;

  assign no_delay = dt_disable | (dt_count == '0);
  assign gate     = gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else if (!req) begin
      // Turn-off is never delayed and always clears a pending count.
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else if (gate_q) begin
      cnt_q  <= '0;
    end else if (no_delay) begin
      gate_q <= 1'b1;
    end else if (tick) begin
      if (cnt_q >= dt_count) begin
        gate_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dti_top.sv
module dti_top #(
  parameter int unsigned PHASES = dti_pkg::DEF_PHASES,
  parameter int unsigned CNT_W  = dti_pkg::DEF_CNT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dt_disable,
  input  logic                  half_rate,
  input  logic [CNT_W-1:0]      dt_count,
  input  logic [2*PHASES-1:0]   req,
  output logic [2*PHASES-1:0]   gate
);
  localparam int unsigned NCH = dti_pkg::chan_count(PHASES);

  logic tick;

  dti_tick_gen u_tick (
    .clk       (clk),
    .rst       (rst),
    .half_rate (half_rate),
    .tick      (tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dti_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .dt_disable (dt_disable),
      .dt_count   (dt_count),
      .req        (req[ch]),
      .gate       (gate[ch])
    );
  end
endmodule

// File: rtl/dti_checker.sv
module dti_checker #(
  parameter int unsigned NCH   = 6,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             dt_disable,
  input logic [CNT_W-1:0] dt_count,
  input logic [NCH-1:0]   req,
  input logic [NCH-1:0]   gate
);
  // R1: a cycle of reset leaves every gate low
  a_r1_reset_off: assert property (@(posedge clk)
    rst |=> (gate == '0));

  // R2: a low request forces its gate low after the edge
  a_r2_fall_now: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gate & ~$past(req)) == '0));

  // R3: a gate never rises without its request seen high at that edge
  a_r3_rise_needs_req: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gate & ~$past(gate) & ~$past(req)) == '0));

  // R5: bypass makes each gate a one-cycle copy of its request
  a_r5_bypass_follow: assert property (@(posedge clk) disable iff (rst)
    dt_disable |=> (gate == $past(req)));

  // R6: zero dead time behaves like bypass
  a_r6_zero_follow: assert property (@(posedge clk) disable iff (rst)
    (dt_count == '0) |=> (gate == $past(req)));
endmodule

bind dti_top dti_checker #(.NCH(2*PHASES), .CNT_W(CNT_W)) u_dti_checker (
  .clk        (clk),
  .rst        (rst),
  .dt_disable (dt_disable),
  .dt_count   (dt_count),
  .req        (req),
  .gate       (gate)
);

// File: tb/dti_top_bench.sv
module dti_top_bench;
  localparam int PHASES = 3;
  localparam int CNT_W  = 8;
  localparam int NCH    = 2 * PHASES;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             dt_disable = 1'b0;
  logic             half_rate = 1'b0;
  logic [CNT_W-1:0] dt_count = '0;
  logic [NCH-1:0]   req = '0;
  logic [NCH-1:0]   gate;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dti_top #(.PHASES(PHASES), .CNT_W(CNT_W)) u_dti_top (
    .clk(clk), .rst(rst), .dt_disable(dt_disable), .half_rate(half_rate),
    .dt_count(dt_count), .req(req), .gate(gate)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Raise req[ch] and count edges until gate[ch] is high (0 = never within limit).
  task automatic measure_rise(input int ch, input int limit, output int edges);
    edges = 0;
    @(negedge clk); req[ch] = 1'b1;
    for (int e = 1; e <= limit; e++) begin
      @(posedge clk); @(negedge clk);
      if (gate[ch]) begin edges = e; break; end
    end
  endtask

  task automatic all_off();
    @(negedge clk); req = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; req = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gate == '0, "R1 gates low in reset", int'(gate), 0);
    req = '0; rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(gate == '0, "R1 gates low after reset", int'(gate), 0);
  endtask

  task automatic t_full_rate();
    int e;
    half_rate = 1'b0; dt_disable = 1'b0;
    dt_count = 8'd1; measure_rise(0, 40, e);
    check(e == 2, "R3 n=1 rise edge", e, 2);
    all_off();
    dt_count = 8'd5; measure_rise(1, 40, e);
    check(e == 6, "R3 n=5 rise edge", e, 6);
    // R2: turn-off follows at the next edge
    @(negedge clk); req[1] = 1'b0;
    @(posedge clk); @(negedge clk);
    check(gate[1] == 1'b0, "R2 turn-off next edge", int'(gate[1]), 0);
    all_off();
  endtask

  task automatic t_half_rate();
    int e;
    half_rate = 1'b1; dt_count = 8'd3;
    for (int ph = 0; ph < 2; ph++) begin
      repeat (ph) @(posedge clk);
      measure_rise(2, 40, e);
      check(e == 7 || e == 8, "R4 half-rate rise edge", e, 7);
      all_off();
    end
    half_rate = 1'b0;
  endtask

  task automatic t_bypass_zero();
    int e;
    dt_count = 8'd20; dt_disable = 1'b1;
    measure_rise(3, 40, e);
    check(e == 1, "R5 bypass rise edge", e, 1);
    all_off();
    check(gate[3] == 1'b0, "R5 bypass fall", int'(gate[3]), 0);
    dt_disable = 1'b0; dt_count = 8'd0;
    measure_rise(4, 40, e);
    check(e == 1, "R6 zero count rise edge", e, 1);
    all_off();
  endtask

  task automatic t_cancel();
    int e;
    bit seen = 1'b0;
    dt_count = 8'd10;
    @(negedge clk); req[5] = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); req[5] = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(posedge clk); @(negedge clk);
      if (gate[5]) seen = 1'b1;
    end
    check(!seen, "R7 cancelled request stays off", int'(seen), 0);
    measure_rise(5, 40, e);
    check(e == 11, "R7 full delay after cancel", e, 11);
    all_off();
  endtask

  task automatic t_independent();
    int r0 = 0, r1 = 0;
    dt_count = 8'd4;
    @(negedge clk); req[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk); req[1] = 1'b1;
    for (int c = 3; c <= 20; c++) begin
      @(posedge clk); @(negedge clk);
      if (gate[0] && r0 == 0) r0 = c;
      if (gate[1] && r1 == 0) r1 = c;
    end
    check(r0 == 5, "R8 channel 0 rise edge", r0, 5);
    check(r1 == 7, "R8 channel 1 rise edge", r1, 7);
    all_off();
  endtask

  task automatic t_same_cycle();
    int e;
    bit seen = 1'b0;
    dt_count = 8'd6;
    @(negedge clk); req[2] = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(gate[2] == 1'b0, "R9 still low before expiry", int'(gate[2]), 0);
    req[2] = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(posedge clk); @(negedge clk);
      if (gate[2]) seen = 1'b1;
    end
    check(!seen, "R9 turn-off wins at expiry", int'(seen), 0);
    measure_rise(2, 40, e);
    check(e == 7, "R9 full delay afterwards", e, 7);
    all_off();
  endtask

  initial begin
    t_reset();
    t_full_rate();
    t_half_rate();
    t_bypass_zero();
    t_cancel();
    t_independent();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule